// File: doc/BRIEF.md
# Key-protected independent watchdog timer

This watchdog guards a system against software that has stopped making progress. A slow tick input is divided by a programmable power of two and drives a 12-bit down-counter. Once software has armed the counter with a start key, it must keep writing a refresh key before the counter runs out. If it does not, the block raises a one-clock reset request and the countdown begins again.

All control goes through a small word-wide register bus, with a key register at byte offset 0x00. The division code at 0x04 and the reload value at 0x08 are normally locked. Software can change them only when the most recent key it wrote was the unlock key. A written value is first held as pending. It takes effect on the next divided tick. Until then, a busy flag in the status word at 0x0C shows that the change is still on its way. No key stops the counter once it has been armed. Only the block reset does that.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the division code reads 0, the reload value reads 0xFFF, the status word reads 0, and `wdt_rst_o` is low.
- R2: While locked, a write to offset 0x04 or 0x08 changes neither the read-back value nor the status word.
- R3: A key write of any value other than 0x5555 locks the configuration again.
- R4: An accepted write sets a busy flag in the status word at 0x0C: bit 0 for the division code and bit 1 for the reload value. Software can read the flag before the next divided tick. On that tick the new value is applied and the flag clears.
- R5: Division codes 0 to 6 divide the tick input by 4, 8, 16, 32, 64, 128 and 256. A written code of 7 is stored and used as 6.
- R6: After key 0xCCCC, `wdt_rst_o` rises in the clock after tick number (R+1)·D, where R is the applied reload value and D is the applied divisor.
- R7: `wdt_rst_o` is high for exactly one clock. The counter then reloads, so the next request follows after another (R+1)·D ticks.
- R8: Key 0xAAAA on a running watchdog restarts the countdown and the divider phase, so the next request comes (R+1)·D ticks after that write.
- R9: Once the watchdog is running, no key write and no configuration write stops it.
- R10: Before key 0xCCCC, key 0xAAAA and any number of ticks produce no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable, one clock wide per tick |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| wdt_rst_o | output | 1 | Reset request, one clock wide |

## Verification
The hardest state to reach from the ports is a pending update that is still in flight. Its busy flag must be read between the accepting write and the next divided tick. The phase of the divider at that moment is not visible. The stimulus therefore holds `tick_i` low while it writes and reads the status word. It then releases a burst of ticks long enough to cover the largest divisor. A second hard case is a change of divisor that lands in the middle of a countdown. The cycle-level model covers that case, and it is followed by a measured refresh interval at the new divisor.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;

  localparam int OFF_KEY  = 'h00;
  localparam int OFF_PSC  = 'h04;
  localparam int OFF_RLD  = 'h08;
  localparam int OFF_STAT = 'h0C;

  localparam int STAT_PSC_BIT = 0;
  localparam int STAT_RLD_BIT = 1;
endpackage

// File: rtl/kwdt_field.sv
`timescale 1ns/1ps
// shadowed config field: write lands in shadow, applied on apply_i
module kwdt_field #(
  parameter int W = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  input  logic         apply_i,
  output logic [W-1:0] q_o,
  output logic         pend_o
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL;
      q_o      <= RST_VAL;
      pend_o   <= 1'b0;
    end else begin
      if (apply_i && pend_o) q_o <= shadow_q;
      if (we_i) begin
        shadow_q <= d_i;
        pend_o   <= 1'b1;
      end else if (apply_i) begin
        pend_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kwdt_keys.sv
`timescale 1ns/1ps
module kwdt_keys #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          running_o,
  output logic          unlocked_o,
  output logic          restart_o
);
  import kwdt_pkg::*;

  logic is_start, is_refresh;
  assign is_start   = key_we_i && (wdata_i == DW'(KEY_START));
  assign is_refresh = key_we_i && (wdata_i == DW'(KEY_REFRESH));
  assign restart_o  = is_start || (is_refresh && running_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_o  <= 1'b0;
      unlocked_o <= 1'b0;
    end else begin
      if (is_start) running_o <= 1'b1;
      if (key_we_i) unlocked_o <= (wdata_i == DW'(KEY_UNLOCK));
    end
  end
endmodule

// File: rtl/kwdt_presc.sv
`timescale 1ns/1ps
module kwdt_presc #(
  parameter int PSC_W    = 3,
  parameter int MIN_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             ptick_o
);
  localparam int MAX_CODE = (1 << PSC_W) - 2;
  localparam int CNT_W    = MIN_LOG2 + MAX_CODE;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;

  always_comb begin
    span = (CNT_W+1)'(1) << (int'(code_i) + MIN_LOG2);
    span = span - (CNT_W+1)'(1);
    last = span[CNT_W-1:0];
  end

  assign ptick_o = tick_i && !clear_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= ptick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_count.sv
`timescale 1ns/1ps
module kwdt_count #(
  parameter int RLD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ptick_i,
  input  logic             run_i,
  input  logic [RLD_W-1:0] rld_i,
  output logic             wdt_rst_o
);
  logic [RLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      wdt_rst_o <= 1'b0;
    end else begin
      wdt_rst_o <= 1'b0;
      if (load_i) begin
        cnt_q <= rld_i;
      end else if (ptick_i && run_i) begin
        if (cnt_q == '0) begin
          wdt_rst_o <= 1'b1;
          cnt_q     <= rld_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top #(
  parameter int ADDR_W   = 5,
  parameter int DW       = 16,
  parameter int PSC_W    = 3,
  parameter int RLD_W    = 12,
  parameter int MIN_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              wdt_rst_o
);
  import kwdt_pkg::*;

  localparam int MAX_CODE = (1 << PSC_W) - 2;

  logic hit_key, hit_psc, hit_rld, hit_stat;
  assign hit_key  = addr_i == ADDR_W'(OFF_KEY);
  assign hit_psc  = addr_i == ADDR_W'(OFF_PSC);
  assign hit_rld  = addr_i == ADDR_W'(OFF_RLD);
  assign hit_stat = addr_i == ADDR_W'(OFF_STAT);

  logic running, unlocked, restart, ptick;
  logic pend_psc, pend_rld;
  logic [PSC_W-1:0] psc, psc_wr;
  logic [RLD_W-1:0] rld;

  kwdt_keys #(.DW(DW)) u_keys (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_we_i   (we_i && hit_key),
    .wdata_i    (wdata_i),
    .running_o  (running),
    .unlocked_o (unlocked),
    .restart_o  (restart)
  );

  // the one unused code folds onto the largest divisor
  assign psc_wr = (wdata_i[PSC_W-1:0] > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE)
                                                          : wdata_i[PSC_W-1:0];

  kwdt_field #(.W(PSC_W), .RST_VAL('0)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && hit_psc && unlocked),
    .d_i     (psc_wr),
    .apply_i (ptick),
    .q_o     (psc),
    .pend_o  (pend_psc)
  );

  kwdt_field #(.W(RLD_W), .RST_VAL('1)) u_rld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && hit_rld && unlocked),
    .d_i     (wdata_i[RLD_W-1:0]),
    .apply_i (ptick),
    .q_o     (rld),
    .pend_o  (pend_rld)
  );

  kwdt_presc #(.PSC_W(PSC_W), .MIN_LOG2(MIN_LOG2)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (restart),
    .code_i  (psc),
    .ptick_o (ptick)
  );

  kwdt_count #(.RLD_W(RLD_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (restart),
    .ptick_i   (ptick),
    .run_i     (running),
    .rld_i     (rld),
    .wdt_rst_o (wdt_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_psc) rdata_o = DW'(psc);
    if (hit_rld) rdata_o = DW'(rld);
    if (hit_stat) begin
      rdata_o[STAT_PSC_BIT] = pend_psc;
      rdata_o[STAT_RLD_BIT] = pend_rld;
    end
  end
endmodule

// File: rtl/kwdt_checker.sv
`timescale 1ns/1ps
module kwdt_checker #(
  parameter int ADDR_W = 5,
  parameter int DW     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              unlocked_i,
  input logic              running_i,
  input logic              pend_psc_i,
  input logic              pend_rld_i,
  input logic              wdt_rst_i
);
  import kwdt_pkg::*;

  assert_locked_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_RLD) && !unlocked_i && !pend_rld_i) |=> !pend_rld_i);

  assert_relock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_KEY) && wdata_i != DW'(KEY_UNLOCK)) |=> !unlocked_i);

  assert_busy_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_PSC) && unlocked_i) |=> pend_psc_i);

  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |=> !wdt_rst_i);

  assert_no_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> running_i);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |-> running_i);
endmodule

bind kwdt_top kwdt_checker #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .unlocked_i (unlocked),
  .running_i  (running),
  .pend_psc_i (pend_psc),
  .pend_rld_i (pend_rld),
  .wdt_rst_i  (wdt_rst_o)
);

// File: tb/kwdt_top_test.sv
`timescale 1ns/1ps
module kwdt_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        wdt_rst_o;

  int n_chk = 0, n_fail = 0, n_pulse = 0;

  always #5 clk = ~clk;

  kwdt_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wdt_rst_o(wdt_rst_o)
  );

  // behavioural reference state
  int m_run, m_unl, m_psc, m_rld, m_psh, m_rsh, m_pp, m_pr, m_div, m_cnt, m_rst;

  function automatic int m_read(int a);
    if (a == 4)  return m_psc;
    if (a == 8)  return m_rld;
    if (a == 12) return m_pp + 2 * m_pr;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    int dv, pt, rs, key, d;
    if (!rst_ni) begin
      m_run = 0; m_unl = 0; m_psc = 0; m_rld = 'hFFF; m_psh = 0; m_rsh = 'hFFF;
      m_pp = 0; m_pr = 0; m_div = 0; m_cnt = 'hFFF; m_rst = 0;
    end else begin
      d   = int'(wdata_i);
      key = (we_i && addr_i == 0) ? 1 : 0;
      rs  = (key != 0 && (d == 'hCCCC || (d == 'hAAAA && m_run != 0))) ? 1 : 0;
      dv  = 4 << m_psc;
      pt  = (rs == 0 && tick_i && m_div >= dv - 1) ? 1 : 0;
      m_rst = (pt != 0 && m_run != 0 && m_cnt == 0) ? 1 : 0;
      if (rs != 0) begin
        m_cnt = m_rld; m_div = 0;
      end else if (tick_i) begin
        m_div = (pt != 0) ? 0 : m_div + 1;
        if (pt != 0 && m_run != 0) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
      end
      if (key != 0 && d == 'hCCCC) m_run = 1;
      if (pt != 0 && m_pp != 0) begin m_psc = m_psh; m_pp = 0; end
      if (pt != 0 && m_pr != 0) begin m_rld = m_rsh; m_pr = 0; end
      if (we_i && addr_i == 4 && m_unl != 0) begin
        m_psh = ((d & 7) > 6) ? 6 : (d & 7); m_pp = 1;
      end
      if (we_i && addr_i == 8 && m_unl != 0) begin
        m_rsh = d & 'hFFF; m_pr = 1;
      end
      if (key != 0) m_unl = (d == 'h5555) ? 1 : 0;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always begin
    @(negedge clk); #1;
    if (rst_ni) begin
      check("R7 wdt_rst_o vs model", int'(wdt_rst_o), m_rst);
      check("R4 rdata vs model", int'(rdata_o), m_read(int'(addr_i)));
      if (wdt_rst_o) n_pulse++;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); tick_i = 0; we_i = 1; addr_i = 5'(a); wdata_i = 16'(d);
    @(negedge clk); we_i = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); tick_i = 0; addr_i = 5'(a); #1; v = int'(rdata_o);
  endtask

  task automatic ticks(int n);
    repeat (n) begin @(negedge clk); tick_i = 1; end
    @(negedge clk); tick_i = 0;
  endtask

  task automatic count_to_rst(output int n);
    n = 0;
    @(negedge clk); tick_i = 1;
    repeat (5000) begin
      @(posedge clk); n++;
      @(negedge clk); #1;
      if (wdt_rst_o) break;
    end
    tick_i = 0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1
    rd(4, v); check("R1 psc", v, 0);
    rd(8, v); check("R1 rld", v, 'hFFF);
    rd(12, v); check("R1 stat", v, 0);
    check("R1 rst", int'(wdt_rst_o), 0);
    // R2
    wr(4, 3); wr(8, 9);
    rd(12, v); check("R2 stat", v, 0);
    rd(4, v); check("R2 psc", v, 0);
    rd(8, v); check("R2 rld", v, 'hFFF);
    // R3
    wr(0, 'h5555); wr(0, 'h1234); wr(8, 5);
    rd(12, v); check("R3 stat", v, 0);
    rd(8, v); check("R3 rld", v, 'hFFF);
    // R4
    wr(0, 'h5555); wr(4, 1);
    rd(12, v); check("R4 busy visible", v, 1);
    rd(4, v); check("R4 not yet applied", v, 0);
    ticks(300);
    rd(12, v); check("R4 busy cleared", v, 0);
    rd(4, v); check("R4 applied", v, 1);
    // R5
    wr(4, 7); wr(8, 5);
    rd(12, v); check("R5 both busy", v, 3);
    ticks(300);
    rd(4, v); check("R5 code 7 folds", v, 6);
    rd(8, v); check("R5 rld", v, 5);
    wr(4, 0); ticks(300);
    rd(4, v); check("R5 code 0", v, 0);
    // R10
    wr(0, 'hAAAA); ticks(200);
    check("R10 no pulse before start", n_pulse, 0);
    // R6
    wr(0, 'hCCCC); count_to_rst(n); check("R6 first timeout", n, 24);
    // R7
    count_to_rst(n); check("R7 periodic timeout", n, 24);
    // R8
    ticks(10); wr(0, 'hAAAA); count_to_rst(n); check("R8 refresh", n, 24);
    // R9
    wr(0, 'h0000); wr(0, 'h5555); wr(0, 'h1234);
    count_to_rst(n); check("R9 still running", n, 24);
    // R5 divisor 16 mid-run
    wr(0, 'h5555); wr(4, 2); wr(0, 0); ticks(300);
    wr(0, 'hAAAA); count_to_rst(n); check("R5 div16 timeout", n, 96);
    ticks(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule